// File: doc/BRIEF.md
# PUF Challenge Sequencer

This block runs one challenge cycle on a bank of delay-race PUF cells, where each cell is a pair of cross-coupled latches. A host raises a one-bit trigger and presents a 16-bit duration. The sequencer first holds every cell in its cleared state for a fixed number of clock cycles. It then drives a generate level for the programmed number of cycles, so that each latch pair can race and settle. Finally it raises a done flag.

On the clock edge where the generate phase ends, a 128-bit response register takes a copy of the cell outputs. The register then holds that value. The host reads the response while done is high, and lowering the trigger acknowledges the read. Done acts as the valid for the response and a low trigger acts as the acknowledge, so the host can hold the result for as long as it needs. The cell bank, its placement and the host register file are not part of this block.

Top module: `puf_seq_ctrl`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the first cycle after it, `cell_clear_o`, `cell_gen_o` and `done_o` are low and `response_o` is all zeros.
- R2: When `trig_i` is high in the idle state, `cell_clear_o` is high for exactly 4 consecutive cycles, starting the cycle after the trigger is sampled.
- R3: `cell_gen_o` rises in the cycle right after `cell_clear_o` falls. It stays high for exactly D cycles, where D is the duration sampled with the trigger. `cell_clear_o` and `cell_gen_o` are never high together.
- R4: A duration of 0 gives a generate phase of exactly one cycle.
- R5: The duration is sampled only when the trigger is accepted. Later changes to `duration_i` do not alter the running sequence.
- R6: `done_o` rises in the cycle right after `cell_gen_o` falls. It stays high for as long as `trig_i` stays high.
- R7: With `done_o` high and `trig_i` low, `done_o` falls on the next cycle and the block returns to idle. With the trigger low, idle stays idle.
- R8: Lowering or raising `trig_i` during the clear or generate phase neither aborts nor restarts the sequence.
- R9: `response_o` takes the value of `cell_bits_i` from the last generate cycle. After that, it changes only at the end of a later generate phase or on reset. Changes on `cell_bits_i` while done is high do not affect it.
- R10: A reset in the middle of a sequence returns the block to idle, with all outputs low and the response cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Starts a sequence from idle; holds done while high |
| duration_i | input | 16 | Generate length in clock cycles (0 treated as 1) |
| cell_bits_i | input | 128 | Settled outputs of the cell bank |
| cell_clear_o | output | 1 | Holds all cell latches at 0 |
| cell_gen_o | output | 1 | Generate level that lets the latch pairs race |
| done_o | output | 1 | Response valid and settled |
| response_o | output | 128 | Captured PUF response |

## Verification
The hardest situation to reach from the ports is a change on the trigger or on the duration while the block is busy. Each run of the vector table rewrites `duration_i` one cycle after the trigger is accepted. Selected rows also drop the trigger and raise it again during the clear phase, and one row lets it fall during generate so that done lasts only a single cycle. After the capture, the behavioural cell bank flips its outputs, which exposes any resampling of the response. A reset is also forced in the middle of the generate phase.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RACE  = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_t;

  localparam int unsigned DEF_DUR_W      = 16;
  localparam int unsigned DEF_RESP_W     = 128;
  localparam int unsigned DEF_CLR_CYCLES = 4;
endpackage

// File: rtl/puf_seq_timer.sv
module puf_seq_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/puf_seq_fsm.sv
module puf_seq_fsm
  import puf_seq_pkg::*;
#(
  parameter int unsigned DUR_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned CLR_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [DUR_W-1:0] duration_i,
  input  logic [CNT_W-1:0] cnt_i,
  output seq_state_t       state_q_o,
  output seq_state_t       state_d_o,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             capture_o
);
  localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(CLR_CYCLES - 1);

  seq_state_t       state_q, state_d;
  logic [DUR_W-1:0] term_q;
  logic             last_clear, last_race;

  // Terminal count of the generate phase; a zero duration maps to one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      term_q <= '0;
    end else if (state_q == ST_IDLE && trig_i) begin
      term_q <= (duration_i == '0) ? '0 : duration_i - 1'b1;
    end
  end

  assign last_clear = (cnt_i == CLR_LAST);
  assign last_race  = (cnt_i == CNT_W'(term_q));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (trig_i)     state_d = ST_CLEAR;
      ST_CLEAR: if (last_clear) state_d = ST_RACE;
      ST_RACE:  if (last_race)  state_d = ST_HOLD;
      ST_HOLD:  if (!trig_i)    state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign cnt_clr_o = (state_d != state_q);
  assign cnt_en_o  = (state_q == ST_CLEAR) || (state_q == ST_RACE);
  assign capture_o = (state_q == ST_RACE) && last_race;
  assign state_q_o = state_q;
  assign state_d_o = state_d;
endmodule

// File: rtl/puf_resp_capture.sv
module puf_resp_capture #(
  parameter int unsigned RESP_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [RESP_W-1:0] bits_i,
  output logic [RESP_W-1:0] resp_o
);
  logic [RESP_W-1:0] resp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q <= '0;
    end else if (capture_i) begin
      resp_q <= bits_i;
    end
  end

  assign resp_o = resp_q;
endmodule

// File: rtl/puf_seq_ctrl.sv
module puf_seq_ctrl
  import puf_seq_pkg::*;
#(
  parameter int unsigned DUR_W      = DEF_DUR_W,
  parameter int unsigned RESP_W     = DEF_RESP_W,
  parameter int unsigned CLR_CYCLES = DEF_CLR_CYCLES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [DUR_W-1:0]  duration_i,
  input  logic [RESP_W-1:0] cell_bits_i,
  output logic              cell_clear_o,
  output logic              cell_gen_o,
  output logic              done_o,
  output logic [RESP_W-1:0] response_o
);
  localparam int unsigned CLR_W = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;
  localparam int unsigned CNT_W = (DUR_W > CLR_W) ? DUR_W : CLR_W;

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_en, capture;
  logic             clear_q, gen_q, done_q;

  puf_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  puf_seq_fsm #(
    .DUR_W      (DUR_W),
    .CNT_W      (CNT_W),
    .CLR_CYCLES (CLR_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .trig_i     (trig_i),
    .duration_i (duration_i),
    .cnt_i      (cnt),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .cnt_clr_o  (cnt_clr),
    .cnt_en_o   (cnt_en),
    .capture_o  (capture)
  );

  puf_resp_capture #(.RESP_W(RESP_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .capture_i (capture),
    .bits_i    (cell_bits_i),
    .resp_o    (response_o)
  );

  // Outputs come straight from flops decoded off the next state,
  // so the latch bank never sees decode glitches.
  always_ff @(posedge clk) begin
    if (rst) begin
      clear_q <= 1'b0;
      gen_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      clear_q <= (state_d == ST_CLEAR);
      gen_q   <= (state_d == ST_RACE);
      done_q  <= (state_d == ST_HOLD);
    end
  end

  assign cell_clear_o = clear_q;
  assign cell_gen_o   = gen_q;
  assign done_o       = done_q;

  logic unused_state;
  assign unused_state = ^state_q;
endmodule

// File: rtl/puf_seq_ctrl_chk.sv
module puf_seq_ctrl_chk #(
  parameter int unsigned RESP_W     = 128,
  parameter int unsigned CLR_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              trig_i,
  input logic              cell_clear_o,
  input logic              cell_gen_o,
  input logic              done_o,
  input logic [RESP_W-1:0] response_o
);
  logic       past_ok;
  logic [7:0] clr_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      clr_run <= '0;
    end else begin
      past_ok <= 1'b1;
      if (!cell_clear_o)        clr_run <= '0;
      else if (clr_run != 8'hFF) clr_run <= clr_run + 8'd1;
    end
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    !past_ok |-> (!cell_clear_o && !cell_gen_o && !done_o && response_o == '0));

  p_clear_short_r2: assert property (@(posedge clk) disable iff (rst)
    cell_clear_o |-> (clr_run < 8'(CLR_CYCLES)));

  p_clear_len_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $fell(cell_clear_o)) |-> (clr_run == 8'(CLR_CYCLES)));

  p_gen_after_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $fell(cell_clear_o)) |-> cell_gen_o);

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(cell_clear_o && cell_gen_o));

  p_done_after_gen_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $fell(cell_gen_o)) |-> done_o);

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && trig_i) |=> done_o);

  p_done_release_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !trig_i) |=> !done_o);

  p_start_from_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $rose(cell_clear_o)) |-> $past(!cell_gen_o && !done_o));

  p_resp_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$stable(response_o)) |-> $fell(cell_gen_o));
endmodule

bind puf_seq_ctrl puf_seq_ctrl_chk #(.RESP_W(RESP_W), .CLR_CYCLES(CLR_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .trig_i       (trig_i),
  .cell_clear_o (cell_clear_o),
  .cell_gen_o   (cell_gen_o),
  .done_o       (done_o),
  .response_o   (response_o)
);

// File: tb/sim_puf_seq_ctrl.sv
`timescale 1ns/1ps
module sim_puf_seq_ctrl;
  localparam int NV = 6;
  localparam logic [15:0]  DUR_T [NV] = '{16'd1, 16'd0, 16'd2, 16'd5, 16'd300, 16'd7};
  localparam logic [127:0] PAT_T [NV] = '{
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    128'hFFFF_0000_FFFF_0000_AAAA_5555_AAAA_5555,
    128'h8000_0000_0000_0000_0000_0000_0000_0001,
    128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0,
    128'h5A5A_5A5A_A5A5_A5A5_0F0F_0F0F_F0F0_F0F0,
    128'h0000_0000_0000_0001_0000_0000_0000_0000};
  localparam int MODE_T [NV] = '{0, 0, 1, 0, 1, 2};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         trig_i = 1'b0;
  logic [15:0]  duration_i = '0;
  logic [127:0] cell_bits_i;
  logic         cell_clear_o, cell_gen_o, done_o;
  logic [127:0] response_o;
  logic [127:0] pattern_q = '0;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  // Behavioural cell bank: cleared cells read 0, otherwise the settled pattern.
  always_comb cell_bits_i = cell_clear_o ? '0 : pattern_q;

  puf_seq_ctrl u0 (
    .clk(clk), .rst(rst), .trig_i(trig_i), .duration_i(duration_i),
    .cell_bits_i(cell_bits_i), .cell_clear_o(cell_clear_o),
    .cell_gen_o(cell_gen_o), .done_o(done_o), .response_o(response_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: plain; 1: trigger toggled during clear (R8); 2: trigger dropped during generate
  task automatic run_seq(input logic [15:0] dur, input logic [127:0] pat, input int mode);
    int deff = (dur == 16'd0) ? 1 : int'(dur);
    int nclr = 0, ngen = 0, fclr = -1, fgen = -1, fdone = -1;
    bit ovl = 0;
    @(negedge clk);
    pattern_q  = pat;
    duration_i = dur;
    trig_i     = 1'b1;
    for (int i = 1; i <= 70000 && fdone < 0; i++) begin
      @(negedge clk);
      if (i == 1) duration_i = ~dur;  // R5: late change must be ignored
      if (cell_clear_o) begin nclr++; if (fclr < 0) fclr = i; end
      if (cell_gen_o)   begin ngen++; if (fgen < 0) fgen = i; end
      if (cell_clear_o && cell_gen_o) ovl = 1;
      if (done_o && fdone < 0) fdone = i;
      if (mode == 1 && i == 2) trig_i = 1'b0;
      if (mode == 1 && i == 3) trig_i = 1'b1;
      if (mode == 2 && i == 5) trig_i = 1'b0;
    end
    chk(fclr == 1, "R2 clear start", fclr, 1);
    chk(nclr == 4, "R2 clear length", nclr, 4);
    chk(fgen == 5, "R3 gen start", fgen, 5);
    chk(ngen == deff, (dur == 0) ? "R4 zero duration gen length" : "R3/R5 gen length", ngen, deff);
    chk(!ovl, "R3 clear/gen overlap", ovl, 0);
    chk(fdone == 5 + deff, "R6 done start", fdone, 5 + deff);
    chk(response_o == pat, "R9 captured response", response_o, pat);
    if (mode == 1) chk(nclr == 4 && ngen == deff, "R8 busy trigger ignored", ngen, deff);
    pattern_q = ~pat;
    if (mode == 2) begin
      @(negedge clk);
      chk(done_o == 1'b0, "R7 done lasts one cycle when trigger already low", done_o, 0);
    end else begin
      @(negedge clk);
      chk(done_o == 1'b1, "R6 done holds while trigger high", done_o, 1);
      chk(response_o == pat, "R9 response unaffected by cell changes", response_o, pat);
      trig_i = 1'b0;
      @(negedge clk);
      chk(done_o == 1'b0, "R7 done falls after trigger low", done_o, 0);
    end
    @(negedge clk);
    chk(!cell_clear_o && !cell_gen_o && !done_o, "R7 idle stays idle", {cell_clear_o, cell_gen_o, done_o}, 0);
    chk(response_o == pat, "R9 response held in idle", response_o, pat);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cell_clear_o && !cell_gen_o && !done_o, "R1 outputs low in reset", {cell_clear_o, cell_gen_o, done_o}, 0);
    chk(response_o == '0, "R1 response cleared", response_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!cell_clear_o && !cell_gen_o && !done_o, "R1 outputs low after reset", {cell_clear_o, cell_gen_o, done_o}, 0);

    for (int v = 0; v < NV; v++) run_seq(DUR_T[v], PAT_T[v], MODE_T[v]);

    // R10: reset in the middle of the generate phase
    @(negedge clk);
    pattern_q = 128'h1;
    duration_i = 16'd20;
    trig_i = 1'b1;
    repeat (7) @(negedge clk);
    chk(cell_gen_o == 1'b1, "R10 in generate before reset", cell_gen_o, 1);
    rst = 1'b1;
    trig_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk(!cell_clear_o && !cell_gen_o && !done_o, "R10 outputs low after mid reset", {cell_clear_o, cell_gen_o, done_o}, 0);
    chk(response_o == '0, "R10 response cleared", response_o, 0);
    repeat (3) @(negedge clk);
    chk(!cell_clear_o && !cell_gen_o && !done_o, "R10 stays idle", {cell_clear_o, cell_gen_o, done_o}, 0);

    // Boundary: largest duration
    run_seq(16'hFFFF, 128'hC3C3_0000_0000_0000_0000_0000_0000_3C3C, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule